// File: doc/BRIEF.md
# Banked RAM Access Privilege Checker

This block guards a 32-Kbyte RAM array that is split into four 8-Kbyte blocks. A 32-bit control word holds three bits for each block. Two of them restrict access: a fetch-block bit, which forbids instruction fetches, and a supervisor-only bit, which forbids user-mode accesses. The third bit is stored only. The restrictions apply only while the processor's data-relocate status bit is set. When that bit is clear, every access passes whatever the control word holds.

Each access is checked in the cycle its valid strobe is high. A registered error flag reports a violation one cycle later. The caller presents the access address relative to the array base: only the 15-bit offset within the array enters the block. Software writes the control word as a whole 32-bit value and reads it back unchanged.

Top module: `pg_bank_guard`

## Requirements
- R1: After a synchronous reset, the control word reads back as all zeros and the error flag is low.
- R2: A cycle with `cfg_we` high stores the full 32-bit `cfg_wdata`. All bits, including those with no function, read back unchanged on `cfg_rdata` from the next cycle.
- R3: Offset bits [14:13] select the block (0 through 3). Bits [12:0] have no effect on the check. An access that breaks no rule gives no error.
- R4: With `relocate_en` high, an instruction fetch (`acc_fetch`=1) to block b gives an error when that block's fetch-block bit is 1. A data access to the same block gives no error. The fetch-block bit of block b sits at LSB-0 position 10-3b, so it is bit 10, 7, 4 or 1.
- R5: With `relocate_en` high, a user access (`acc_user`=1) to block b gives an error when that block's supervisor-only bit is 1. A supervisor access gives no error. The supervisor-only bit of block b sits at position 9-3b, so it is bit 9, 6, 3 or 0.
- R6: With `relocate_en` low, no access gives an error, whatever the control word holds.
- R7: The stored-only bit of block b, at position 11-3b, has no effect on any check.
- R8: No error is reported for a cycle in which `acc_valid` is low.
- R9: `err_o` goes high in the cycle after a violating access and lasts one cycle, unless the next access also violates. The flag is the OR of the fetch rule and the user rule.
- R10: An access made in the same cycle as a control write is checked against the control word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| acc_valid | input | 1 | Access valid strobe |
| acc_addr | input | 15 | Access offset within the array |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_user | input | 1 | 1 = user mode, 0 = supervisor |
| relocate_en | input | 1 | Processor data-relocate status bit |
| err_o | output | 1 | Registered privilege violation flag |

## Verification
A corrupted control word shows on `cfg_rdata` in the cycle after the write. When it hits a fetch-block or supervisor-only bit, it also shows as a missing or spurious `err_o` pulse one cycle after the next access to that block. A wrong block decode shows as an error charged to the neighbouring block's bits, again one cycle after the access. The bench sweeps every combination of the eight restricting bits against every block, mode, fetch type, relocate state and strobe. It varies the offset's low bits and the stored-only bits alongside, so such faults surface within a cycle of the access that exposes them.

// File: rtl/pg_guard_pkg.sv
package pg_guard_pkg;
  localparam int CTL_W        = 32;
  localparam int BITS_PER_BLK = 3;
  localparam int OFS_R        = 2;  // stored-only bit, highest in a block's field
  localparam int OFS_D        = 1;  // fetch-block bit
  localparam int OFS_S        = 0;  // supervisor-only bit

  typedef struct packed {
    logic valid;
    logic fetch;
    logic user;
    logic reloc;
  } acc_attr_t;
endpackage

// File: rtl/pg_ctl_reg.sv
module pg_ctl_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/pg_blk_decode.sv
module pg_blk_decode #(
  parameter int BLK_AW  = 13,
  parameter int NUM_BLK = 4,
  localparam int SEL_W  = $clog2(NUM_BLK),
  localparam int ARR_AW = BLK_AW + SEL_W
) (
  input  logic [ARR_AW-1:0] ofs,
  output logic [SEL_W-1:0]  sel
);
  always_comb sel = ofs[ARR_AW-1:BLK_AW];
endmodule

// File: rtl/pg_rule_eval.sv
module pg_rule_eval
  import pg_guard_pkg::*;
#(
  parameter int NUM_BLK = 4,
  localparam int SEL_W  = $clog2(NUM_BLK)
) (
  input  acc_attr_t          attr,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_BLK-1:0] fetch_blk,
  input  logic [NUM_BLK-1:0] sup_only,
  output logic               fetch_viol,
  output logic               user_viol
);
  logic armed;
  always_comb begin
    armed      = attr.valid && attr.reloc;
    fetch_viol = armed && attr.fetch && fetch_blk[sel];
    user_viol  = armed && attr.user  && sup_only[sel];
  end
endmodule

// File: rtl/pg_bank_guard.sv
module pg_bank_guard
  import pg_guard_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int BLK_AW  = 13,
  localparam int SEL_W  = $clog2(NUM_BLK),
  localparam int ARR_AW = BLK_AW + SEL_W,
  localparam int FLD_W  = NUM_BLK * BITS_PER_BLK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CTL_W-1:0]  cfg_wdata,
  output logic [CTL_W-1:0]  cfg_rdata,
  input  logic              acc_valid,
  input  logic [ARR_AW-1:0] acc_addr,
  input  logic              acc_fetch,
  input  logic              acc_user,
  input  logic              relocate_en,
  output logic              err_o
);
  logic [CTL_W-1:0]   ctl_q;
  logic [SEL_W-1:0]   blk_sel;
  logic [NUM_BLK-1:0] fetch_blk;
  logic [NUM_BLK-1:0] sup_only;
  logic               fetch_viol;
  logic               user_viol;
  acc_attr_t          attr;

  pg_ctl_reg #(.W(CTL_W)) u_ctl (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(ctl_q)
  );

  assign cfg_rdata = ctl_q;

  // Block 0 owns the top field of the low FLD_W bits; later blocks follow downward.
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_fld
    localparam int BASE = FLD_W - BITS_PER_BLK * (b + 1);
    assign fetch_blk[b] = ctl_q[BASE + OFS_D];
    assign sup_only[b]  = ctl_q[BASE + OFS_S];
  end

  pg_blk_decode #(.BLK_AW(BLK_AW), .NUM_BLK(NUM_BLK)) u_dec (
    .ofs(acc_addr), .sel(blk_sel)
  );

  always_comb begin
    attr.valid = acc_valid;
    attr.fetch = acc_fetch;
    attr.user  = acc_user;
    attr.reloc = relocate_en;
  end

  pg_rule_eval #(.NUM_BLK(NUM_BLK)) u_eval (
    .attr(attr), .sel(blk_sel), .fetch_blk(fetch_blk), .sup_only(sup_only),
    .fetch_viol(fetch_viol), .user_viol(user_viol)
  );

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= fetch_viol | user_viol;
  end

  // R2
  cfg_store_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));
  // R4
  fetch_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && relocate_en && acc_fetch && fetch_blk[blk_sel]) |=> err_o);
  // R5
  user_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && relocate_en && acc_user && sup_only[blk_sel]) |=> err_o);
  // R6
  no_err_unrelocated_chk: assert property (@(posedge clk) disable iff (rst)
    (!relocate_en) |=> !err_o);
  // R8
  no_err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid) |=> !err_o);
endmodule

// File: tb/sim_pg_bank_guard.sv
module sim_pg_bank_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        acc_valid;
  logic [14:0] acc_addr;
  logic        acc_fetch;
  logic        acc_user;
  logic        relocate_en;
  logic        err_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  pg_bank_guard u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_fetch(acc_fetch), .acc_user(acc_user), .relocate_en(relocate_en),
    .err_o(err_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R2", cfg_rdata, v);
  endtask

  task automatic access(input logic v, input logic [14:0] a, input logic f,
                        input logic u, input logic r, input logic exp, input string tag);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_fetch = f; acc_user = u; relocate_en = r;
    @(negedge clk);
    acc_valid = 1'b0;
    check(tag, {31'd0, err_o}, {31'd0, exp});
  endtask

  function automatic logic [31:0] build_cfg(input int i);
    logic [31:0] c;
    c = (i * 32'h0013_5790) & 32'hFFFF_F000;
    for (int b = 0; b < 4; b++) begin
      c[10 - 3*b] = i[2*b];
      c[9 - 3*b]  = i[2*b + 1];
      c[11 - 3*b] = i[(2*b + 3) % 8];
    end
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; acc_valid = 1'b0;
    acc_addr = '0; acc_fetch = 1'b0; acc_user = 1'b0; relocate_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", cfg_rdata, 32'd0);
    check("R1", {31'd0, err_o}, 32'd0);
    rst = 1'b0;

    // R7: stored-only bits all set, no restriction bits set
    write_cfg(32'h0000_0924);
    for (int b = 0; b < 4; b++)
      access(1'b1, 15'(b << 13), 1'b1, 1'b1, 1'b1, 1'b0, "R7");

    // Exhaustive sweep over restriction bits, blocks and access attributes
    for (int i = 0; i < 256; i++) begin
      logic [31:0] c;
      c = build_cfg(i);
      write_cfg(c);
      for (int a = 0; a < 64; a++) begin
        logic v, r, f, u, d, s, e;
        int b;
        string tag;
        v = a[0]; r = a[1]; f = a[2]; u = a[3]; b = (a >> 4) & 3;
        d = c[10 - 3*b]; s = c[9 - 3*b];
        e = v && r && ((f && d) || (u && s));
        if (!v)            tag = "R8";
        else if (!r)       tag = "R6";
        else if (f && d)   tag = "R4";
        else if (u && s)   tag = "R5";
        else               tag = "R3";
        access(v, 15'((b << 13) | ((i * 37 + a * 11) & 13'h1FFF)), f, u, r, e, tag);
      end
    end

    // R9: one-cycle pulse after a violating fetch, then low when idle
    write_cfg(32'h0000_0400);
    access(1'b1, 15'h0010, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
    @(negedge clk);
    check("R9", {31'd0, err_o}, 32'd0);

    // R10: access in the same cycle as a write uses the old word
    write_cfg(32'd0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h0000_0002;
    acc_valid = 1'b1; acc_addr = 15'h6000; acc_fetch = 1'b1; acc_user = 1'b0; relocate_en = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R10", {31'd0, err_o}, 32'd0);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R10", {31'd0, err_o}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule